// File: doc/BRIEF.md
# Flash ISP Command Controller

This block sits on the CPU's special-function-register bus in front of an on-chip flash array. It holds a control register, a mode register, two address bytes and a write-only command port. A flash operation starts only when two fixed key bytes reach the command port back to back while flash modification is enabled. The operation is a read, a program or a page erase, chosen by the mode register. When it starts, the block issues a one-cycle strobe to the flash array that carries the operation and the 16-bit address. It then holds the CPU for a number of cycles set by the operation and a wait selection.

The control register also carries a boot-source bit and a self-clearing software reset trigger. A software reset clears the working registers and the key detector. It does not clear the enable and boot-source bits, which only the power-up reset clears. Reads of the command port return one of two device-identification bytes, chosen by the low address byte.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After power-up reset (rst_ni low), every register reads 0, and cpu_hold_o, flash_stb_o, sw_rst_o and boot_sel_o are 0.
- R2: Register selects are 0 control, 1 mode, 2 address high, 3 address low and 4 command. The control register maps enable to bit 7, boot source to bit 6 (driven on boot_sel_o) and wait selection to bits 2:0. It reads back as {enable, boot, 0, 00, wait}.
- R3: Writing control bit 5 as 1 gives sw_rst_o high for exactly the one cycle after the write, and bit 5 reads as 0. Writing it as 0 gives no pulse. Bus writes during the pulse cycle are dropped.
- R4: The software reset pulse clears the mode register, both address bytes, the wait field and any half-received key. Enable and boot source keep their values.
- R5: With enable at 1, command writes of 46h followed by B9h start an operation. Writes to other registers in between do not break the sequence. Any other command byte returns the detector to idle, except that 46h arms it again.
- R6: Command writes while enable is 0 are ignored and leave the detector state as it was.
- R7: Mode bits 2:0 equal to 011 select page erase, 010 select program, and every other value selects read. flash_op_o codes these as 11, 10 and 01. On the cycle after the starting write, flash_stb_o is high for one cycle with flash_op_o and flash_addr_o = {high, low}, and cpu_hold_o rises in that same cycle.
- R8: cpu_hold_o stays high for exactly N cycles. With wait 000/001/010/011, N is 43769/21885/10942/5471 for erase, 240/120/60/30 for program and 43/22/11/6 for read.
- R9: Wait values 100 to 111 use the 000 row of the hold table.
- R10: Reading the command port returns F1h when address-low bit 0 is 0 and 10h when it is 1.
- R11: Bus writes are ignored while cpu_hold_o is high, including a write in the last held cycle. The first write accepted is in the cycle after cpu_hold_o falls.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, one cycle per machine cycle by default |
| rst_ni | input | 1 | Active-low asynchronous power-up reset |
| sfr_wr_i | input | 1 | Register write strobe |
| sfr_sel_i | input | 3 | Register select |
| sfr_wdata_i | input | 8 | Write data |
| sfr_rdata_o | output | 8 | Read data for the selected register |
| cpu_hold_o | output | 1 | CPU stall, high while an operation runs |
| flash_stb_o | output | 1 | One-cycle operation strobe to the flash array |
| flash_op_o | output | 2 | Operation code: 01 read, 10 program, 11 erase |
| flash_addr_o | output | 16 | Operation address |
| sw_rst_o | output | 1 | One-cycle software reset pulse |
| boot_sel_o | output | 1 | Boot source: 0 main memory, 1 ISP region |

## Verification
Two functions can meet in one cycle: the end of the hold, and a bus write that the CPU presents while it is still held. The bench drives a mode-register write exactly in the last cycle that cpu_hold_o is high. It then checks that the hold has dropped and that the mode register still reads its old value. A second write in the next free cycle must land. The software reset pulse meets a half-received key in a similar way, and the bench judges this by whether a lone B9h afterwards starts anything.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned ADDR_W = 2 * DATA_W;
  localparam int unsigned SEL_W  = 3;
  localparam int unsigned WAIT_W = 3;
  localparam int unsigned MODE_W = 3;
  localparam int unsigned CNT_W  = 16;

  typedef enum logic [1:0] {
    OP_NONE  = 2'b00,
    OP_READ  = 2'b01,
    OP_PROG  = 2'b10,
    OP_ERASE = 2'b11
  } flash_op_e;

  typedef enum logic [SEL_W-1:0] {
    SEL_CTRL    = 3'd0,
    SEL_MODE    = 3'd1,
    SEL_ADDR_HI = 3'd2,
    SEL_ADDR_LO = 3'd3,
    SEL_CMD     = 3'd4
  } reg_sel_e;

  typedef enum logic {
    UL_IDLE  = 1'b0,
    UL_ARMED = 1'b1
  } unlock_state_e;

  localparam logic [DATA_W-1:0] KEY_FIRST  = 8'h46;
  localparam logic [DATA_W-1:0] KEY_SECOND = 8'hB9;
  localparam logic [DATA_W-1:0] DEV_ID_HI  = 8'hF1;
  localparam logic [DATA_W-1:0] DEV_ID_LO  = 8'h10;

  function automatic flash_op_e decode_op(input logic [MODE_W-1:0] mode);
    case (mode)
      3'b011:  return OP_ERASE;
      3'b010:  return OP_PROG;
      default: return OP_READ;
    endcase
  endfunction

  // rows 1xx fall back to the slowest-clock row
  function automatic logic [CNT_W-1:0] hold_len(input flash_op_e op, input logic [WAIT_W-1:0] w);
    logic [1:0] row;
    row = w[2] ? 2'd0 : w[1:0];
    case (op)
      OP_ERASE: case (row)
        2'd0: return 16'd43769;
        2'd1: return 16'd21885;
        2'd2: return 16'd10942;
        default: return 16'd5471;
      endcase
      OP_PROG: case (row)
        2'd0: return 16'd240;
        2'd1: return 16'd120;
        2'd2: return 16'd60;
        default: return 16'd30;
      endcase
      default: case (row)
        2'd0: return 16'd43;
        2'd1: return 16'd22;
        2'd2: return 16'd11;
        default: return 16'd6;
      endcase
    endcase
  endfunction
endpackage

// File: rtl/fcc_regs.sv
module fcc_regs
  import flash_cmd_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [SEL_W-1:0]  sel_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              isp_en_o,
  output logic              boot_sel_o,
  output logic [WAIT_W-1:0] wait_o,
  output logic [MODE_W-1:0] mode_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              sw_rst_o,
  output logic [DATA_W-1:0] rdata_o
);
  logic              isp_en_q, boot_sel_q, swrst_q;
  logic [WAIT_W-1:0] wait_q;
  logic [MODE_W-1:0] mode_q;
  logic [DATA_W-1:0] hi_q, lo_q;
  logic              ctrl_wr;

  assign ctrl_wr = wr_i && (sel_i == SEL_CTRL) && !swrst_q;

  // power-up domain only
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      isp_en_q   <= 1'b0;
      boot_sel_q <= 1'b0;
    end else if (ctrl_wr) begin
      isp_en_q   <= wdata_i[7];
      boot_sel_q <= wdata_i[6];
    end
  end

  // cleared by either reset
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      swrst_q <= 1'b0;
      wait_q  <= '0;
      mode_q  <= '0;
      hi_q    <= '0;
      lo_q    <= '0;
    end else if (swrst_q) begin
      swrst_q <= 1'b0;
      wait_q  <= '0;
      mode_q  <= '0;
      hi_q    <= '0;
      lo_q    <= '0;
    end else if (wr_i) begin
      case (sel_i)
        SEL_CTRL: begin
          swrst_q <= wdata_i[5];
          wait_q  <= wdata_i[WAIT_W-1:0];
        end
        SEL_MODE:    mode_q <= wdata_i[MODE_W-1:0];
        SEL_ADDR_HI: hi_q   <= wdata_i;
        SEL_ADDR_LO: lo_q   <= wdata_i;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (sel_i)
      SEL_CTRL:    rdata_o = {isp_en_q, boot_sel_q, 1'b0, 2'b00, wait_q};
      SEL_MODE:    rdata_o = {{(DATA_W-MODE_W){1'b0}}, mode_q};
      SEL_ADDR_HI: rdata_o = hi_q;
      SEL_ADDR_LO: rdata_o = lo_q;
      SEL_CMD:     rdata_o = lo_q[0] ? DEV_ID_LO : DEV_ID_HI;
      default:     rdata_o = '0;
    endcase
  end

  assign isp_en_o   = isp_en_q;
  assign boot_sel_o = boot_sel_q;
  assign wait_o     = wait_q;
  assign mode_o     = mode_q;
  assign addr_o     = {hi_q, lo_q};
  assign sw_rst_o   = swrst_q;

  // R3
  swrst_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    swrst_q |=> !swrst_q);
  // R4
  sticky_bits_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    swrst_q |=> ($stable(isp_en_q) && $stable(boot_sel_q)));
  // R4
  soft_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    swrst_q |=> (mode_q == '0 && hi_q == '0 && lo_q == '0 && wait_q == '0));
endmodule

// File: rtl/fcc_unlock.sv
module fcc_unlock
  import flash_cmd_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              en_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              launch_o
);
  unlock_state_e state_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               state_q <= UL_IDLE;
    else if (clr_i)            state_q <= UL_IDLE;
    else if (wr_i && en_i)     state_q <= (data_i == KEY_FIRST) ? UL_ARMED : UL_IDLE;
  end

  assign launch_o = wr_i && en_i && (state_q == UL_ARMED) && (data_i == KEY_SECOND);

  // R6
  locked_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !en_i && !clr_i) |=> $stable(state_q));
  // R5
  arm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && en_i && !clr_i && data_i == KEY_FIRST) |=> (state_q == UL_ARMED));
endmodule

// File: rtl/fcc_stall_timer.sv
module fcc_stall_timer
  import flash_cmd_pkg::*;
#(
  parameter int unsigned MC_DIV = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              launch_i,
  input  flash_op_e         op_i,
  input  logic [WAIT_W-1:0] wait_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              busy_o,
  output logic              strobe_o,
  output logic [1:0]        op_o,
  output logic [ADDR_W-1:0] addr_o
);
  logic             busy_q, stb_q, tick;
  logic [CNT_W-1:0] cnt_q;
  flash_op_e        op_q;
  logic [ADDR_W-1:0] addr_q;

  generate
    if (MC_DIV <= 1) begin : g_direct
      assign tick = 1'b1;
    end else begin : g_presc
      localparam int unsigned PRE_W = $clog2(MC_DIV);
      localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(MC_DIV - 1);
      logic [PRE_W-1:0] pre_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                  pre_q <= '0;
        else if (launch_i || !busy_q) pre_q <= '0;
        else if (pre_q == PRE_LAST)   pre_q <= '0;
        else                          pre_q <= pre_q + 1'b1;
      end
      assign tick = (pre_q == PRE_LAST);
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      stb_q  <= 1'b0;
      cnt_q  <= '0;
      op_q   <= OP_NONE;
      addr_q <= '0;
    end else begin
      stb_q <= launch_i;
      if (launch_i) begin
        busy_q <= 1'b1;
        cnt_q  <= hold_len(op_i, wait_i) - 1'b1;
        op_q   <= op_i;
        addr_q <= addr_i;
      end else if (busy_q && tick) begin
        if (cnt_q == '0) busy_q <= 1'b0;
        else             cnt_q  <= cnt_q - 1'b1;
      end
    end
  end

  assign busy_o   = busy_q;
  assign strobe_o = stb_q;
  assign op_o     = op_q;
  assign addr_o   = addr_q;

  // R7
  strobe_on_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_q) |-> stb_q);
  // R7
  strobe_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stb_q |=> !stb_q);
  // R8
  hold_span_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && cnt_q != '0) |=> busy_q);
  // R8
  release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && cnt_q == '0 && tick && !launch_i) |=> !busy_q);
endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
  import flash_cmd_pkg::*;
#(
  parameter int unsigned MC_DIV = 1
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        sfr_wr_i,
  input  logic [2:0]  sfr_sel_i,
  input  logic [7:0]  sfr_wdata_i,
  output logic [7:0]  sfr_rdata_o,
  output logic        cpu_hold_o,
  output logic        flash_stb_o,
  output logic [1:0]  flash_op_o,
  output logic [15:0] flash_addr_o,
  output logic        sw_rst_o,
  output logic        boot_sel_o
);
  logic              busy, sw_rst, isp_en, accept, cmd_wr, launch;
  logic [WAIT_W-1:0] wait_sel;
  logic [MODE_W-1:0] mode;
  logic [ADDR_W-1:0] addr;

  // held CPU and reset pulse cycle drop bus writes
  assign accept = sfr_wr_i && !busy && !sw_rst;
  assign cmd_wr = accept && (sfr_sel_i == SEL_CMD);

  fcc_regs u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_i       (accept),
    .sel_i      (sfr_sel_i),
    .wdata_i    (sfr_wdata_i),
    .isp_en_o   (isp_en),
    .boot_sel_o (boot_sel_o),
    .wait_o     (wait_sel),
    .mode_o     (mode),
    .addr_o     (addr),
    .sw_rst_o   (sw_rst),
    .rdata_o    (sfr_rdata_o)
  );

  fcc_unlock u_unlock (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (sw_rst),
    .en_i     (isp_en),
    .wr_i     (cmd_wr),
    .data_i   (sfr_wdata_i),
    .launch_o (launch)
  );

  fcc_stall_timer #(.MC_DIV(MC_DIV)) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .launch_i (launch),
    .op_i     (decode_op(mode)),
    .wait_i   (wait_sel),
    .addr_i   (addr),
    .busy_o   (busy),
    .strobe_o (flash_stb_o),
    .op_o     (flash_op_o),
    .addr_o   (flash_addr_o)
  );

  assign cpu_hold_o = busy;
  assign sw_rst_o   = sw_rst;

  // R5
  launch_origin_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy) |-> $past(cmd_wr && sfr_wdata_i == KEY_SECOND && isp_en));
  // R11
  busy_write_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && sfr_wr_i) |=> ($stable(mode) && $stable(addr)));
  // R11
  no_relaunch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy |-> !launch);
endmodule

// File: tb/test_flash_cmd_ctrl.sv
`timescale 1ns/1ps
module test_flash_cmd_ctrl;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        sfr_wr_i = 1'b0;
  logic [2:0]  sfr_sel_i = 3'd0;
  logic [7:0]  sfr_wdata_i = 8'h00;
  logic [7:0]  sfr_rdata_o;
  logic        cpu_hold_o, flash_stb_o, sw_rst_o, boot_sel_o;
  logic [1:0]  flash_op_o;
  logic [15:0] flash_addr_o;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;

  flash_cmd_ctrl i_flash_cmd_ctrl (
    .clk_i(clk), .rst_ni(rst_ni), .sfr_wr_i(sfr_wr_i), .sfr_sel_i(sfr_sel_i),
    .sfr_wdata_i(sfr_wdata_i), .sfr_rdata_o(sfr_rdata_o), .cpu_hold_o(cpu_hold_o),
    .flash_stb_o(flash_stb_o), .flash_op_o(flash_op_o), .flash_addr_o(flash_addr_o),
    .sw_rst_o(sw_rst_o), .boot_sel_o(boot_sel_o)
  );

  // {mode, wait, op, cycles}
  localparam logic [23:0] VECS [14] = '{
    {3'b001, 3'b000, 2'b01, 16'd43},
    {3'b001, 3'b001, 2'b01, 16'd22},
    {3'b001, 3'b010, 2'b01, 16'd11},
    {3'b001, 3'b011, 2'b01, 16'd6},
    {3'b010, 3'b000, 2'b10, 16'd240},
    {3'b010, 3'b001, 2'b10, 16'd120},
    {3'b010, 3'b010, 2'b10, 16'd60},
    {3'b010, 3'b011, 2'b10, 16'd30},
    {3'b011, 3'b011, 2'b11, 16'd5471},
    {3'b011, 3'b010, 2'b11, 16'd10942},
    {3'b011, 3'b111, 2'b11, 16'd43769},
    {3'b000, 3'b101, 2'b01, 16'd43},
    {3'b110, 3'b100, 2'b01, 16'd43},
    {3'b010, 3'b110, 2'b10, 16'd240}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] s, input logic [7:0] d);
    @(negedge clk);
    sfr_wr_i = 1'b1; sfr_sel_i = s; sfr_wdata_i = d;
    @(negedge clk);
    sfr_wr_i = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [2:0] s, input logic [7:0] exp);
    sfr_sel_i = s;
    #1;
    chk(req, sfr_rdata_o, exp);
  endtask

  task automatic wait_idle();
    while (cpu_hold_o === 1'b1) @(negedge clk);
  endtask

  task automatic run_op(input logic [2:0] m, input logic [2:0] w, input logic [7:0] hi,
                        input logic [7:0] lo, input logic [1:0] eop, input int ecyc,
                        input string req);
    int n;
    wr(3'd1, {5'b0, m});
    wr(3'd2, hi);
    wr(3'd3, lo);
    wr(3'd0, {2'b10, 3'b000, w});
    wr(3'd4, 8'h46);
    wr(3'd4, 8'hB9);
    chk({req, " strobe"}, flash_stb_o, 1);
    chk({req, " op"}, flash_op_o, eop);
    chk({req, " addr"}, flash_addr_o, {hi, lo});
    n = 0;
    while (cpu_hold_o === 1'b1 && n < 70000) begin
      n++;
      @(negedge clk);
      if (n == 1) chk({req, " strobe width"}, flash_stb_o, 0);
    end
    chk({req, " hold cycles"}, n, ecyc);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 190000) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    // R1
    chk("R1 hold", cpu_hold_o, 0);
    chk("R1 strobe", flash_stb_o, 0);
    chk("R1 swrst", sw_rst_o, 0);
    chk("R1 boot", boot_sel_o, 0);
    rd_chk("R1 ctrl", 3'd0, 8'h00);
    rd_chk("R1 mode", 3'd1, 8'h00);
    @(negedge clk);
    rst_ni = 1'b1;

    // R2
    wr(3'd0, 8'hC5);
    rd_chk("R2 ctrl readback", 3'd0, 8'hC5);
    chk("R2 boot_sel", boot_sel_o, 1);

    // R10
    wr(3'd3, 8'h00);
    rd_chk("R10 id high", 3'd4, 8'hF1);
    wr(3'd3, 8'h01);
    rd_chk("R10 id low", 3'd4, 8'h10);

    // R3 / R4: soft reset with a half-received key
    wr(3'd1, 8'h03);
    wr(3'd2, 8'hAB);
    wr(3'd3, 8'hCD);
    wr(3'd0, 8'hC3);
    wr(3'd4, 8'h46);
    wr(3'd0, 8'hE2);
    chk("R3 pulse high", sw_rst_o, 1);
    @(negedge clk);
    chk("R3 pulse one cycle", sw_rst_o, 0);
    rd_chk("R4 ctrl keeps en/boot, wait cleared", 3'd0, 8'hC0);
    rd_chk("R4 mode cleared", 3'd1, 8'h00);
    rd_chk("R4 addr hi cleared", 3'd2, 8'h00);
    rd_chk("R4 addr lo cleared", 3'd3, 8'h00);
    wr(3'd4, 8'hB9);
    chk("R4 key cleared", cpu_hold_o, 0);
    wr(3'd0, 8'hC0);
    chk("R3 zero no pulse", sw_rst_o, 0);

    // R7 R8 R9: table walk
    for (int i = 0; i < 14; i++) begin
      run_op(VECS[i][23:21], VECS[i][20:18], 8'h30 + 8'(i), 8'h80 + 8'(i),
             VECS[i][17:16], int'(VECS[i][15:0]),
             $sformatf("R7/R8/R9 vec%0d", i));
    end

    // R5: broken sequence, re-arm, interleaved write
    wr(3'd1, 8'h01);
    wr(3'd0, 8'h83);
    wr(3'd4, 8'h46);
    wr(3'd4, 8'h00);
    wr(3'd4, 8'hB9);
    chk("R5 wrong byte breaks", cpu_hold_o, 0);
    wr(3'd4, 8'h46);
    wr(3'd4, 8'h46);
    wr(3'd4, 8'hB9);
    chk("R5 re-arm launches", cpu_hold_o, 1);
    wait_idle();
    wr(3'd4, 8'h46);
    wr(3'd3, 8'h55);
    wr(3'd4, 8'hB9);
    chk("R5 interleave launches", cpu_hold_o, 1);
    chk("R5 interleave addr", flash_addr_o[7:0], 8'h55);
    wait_idle();

    // R6
    wr(3'd0, 8'h03);
    wr(3'd4, 8'h46);
    wr(3'd4, 8'hB9);
    chk("R6 locked no launch", cpu_hold_o, 0);
    wr(3'd0, 8'h83);
    wr(3'd4, 8'hB9);
    chk("R6 locked key not kept", cpu_hold_o, 0);
    wr(3'd4, 8'h46);
    wr(3'd0, 8'h03);
    wr(3'd4, 8'hB9);
    chk("R6 locked write ignored", cpu_hold_o, 0);
    wr(3'd0, 8'h83);
    wr(3'd4, 8'hB9);
    chk("R6 armed state preserved", cpu_hold_o, 1);
    wait_idle();

    // R11: write in last held cycle (read, wait 3 -> 6 cycles)
    wr(3'd1, 8'h01);
    wr(3'd4, 8'h46);
    wr(3'd4, 8'hB9);
    for (int k = 2; k <= 6; k++) @(negedge clk);
    chk("R11 still held", cpu_hold_o, 1);
    sfr_wr_i = 1'b1; sfr_sel_i = 3'd1; sfr_wdata_i = 8'h02;
    @(negedge clk);
    sfr_wr_i = 1'b0;
    chk("R11 released", cpu_hold_o, 0);
    rd_chk("R11 held write dropped", 3'd1, 8'h01);
    wr(3'd1, 8'h02);
    rd_chk("R11 next write lands", 3'd1, 8'h02);

    // R1: power-up reset clears sticky bits
    @(negedge clk);
    rst_ni = 1'b0;
    @(negedge clk);
    #1;
    rd_chk("R1 ctrl after power-up", 3'd0, 8'h00);
    chk("R1 boot after power-up", boot_sel_o, 0);
    rst_ni = 1'b1;
    @(negedge clk);
    finish_run();
  end
endmodule